// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each virtual address issued by a 64-bit RISC core into one of three classes: translated through an external TLB, unmapped with a fixed physical relationship, or illegal. It supports the compatibility 32-bit layout and the extended 64-bit layout. For unmapped addresses it forms the physical address and a cacheable flag by itself. For translated addresses it asks an external lookup unit over a request/response port and merges the returned page number with the page offset.

Failures are reported with an exception code. The code tells an address error apart from a TLB miss, and a load apart from a store. The faulting virtual address is captured in a bad-address register. A request marked lookup-only (a probe) reports failure but has no side effect. Privilege is not checked here.

Top module: `vsd_top`

## Requirements
- R1: With `req_mode64`=0 the segment is `req_vaddr[31:29]`. Values 0 to 3, 6 and 7 go to the TLB. Bits [63:32] are ignored: the address used for the TLB and the bad-address register is bits [31:0] sign-extended to 64 bits.
- R2: With `req_mode64`=0, segment 4 gives `rsp_paddr` = `req_vaddr[28:0]` (zero-extended) with `rsp_cached`=1. Segment 5 gives the same address with `rsp_cached`=0.
- R3: With `req_mode64`=1 the region is `req_vaddr[63:40]`. Regions 0x000000, 0x400000 and 0xC00000 go to the TLB. Region 0xFFFFFF with sub-region `req_vaddr[39:29]` equal to 0x7FE or 0x7FF also goes to the TLB.
- R4: With `req_mode64`=1 and region 0xFFFFFF:
  - Sub-region 0x7FC gives `req_vaddr[28:0]` as a cached access.
  - Sub-region 0x7FD gives the same address as an uncached access.
  - Any other sub-region is an address error.
- R5: With `req_mode64`=1, regions 0x800000 to 0xB80000 in steps of 0x080000 form a direct physical window. `rsp_paddr` = `req_vaddr[35:0]`, and the access is cached unless the attribute `req_vaddr[61:59]` equals 2.
- R6: With `req_mode64`=1, any region not named in R3 to R5 is an address error.
- R7: TLB handshake and result:
  - `tlb_req_valid` rises the cycle after a TLB-bound request is accepted.
  - It stays high with `tlb_req_vaddr` stable until a cycle with `tlb_rsp_valid`=1.
  - The result appears the next cycle.
  - On a hit, `rsp_paddr` = {`tlb_rsp_ppn`, vaddr[11:0]} and `rsp_cached` = `tlb_rsp_cached`.
- R8: Exception codes on `rsp_exc`:
  - 1 is a TLB-miss load; 2 is a TLB-miss store.
  - 3 is an address-error load; 4 is an address-error store.
  - 0 means no exception.
  - With any non-zero code, `rsp_fail`=1 and `badaddr` takes the (R1-adjusted) virtual address.
  - `rsp_paddr` and `rsp_cached` read 0 on any failure.
- R9: For a request with `req_probe`=1, a failure gives `rsp_fail`=1 and `rsp_exc`=0, and `badaddr` keeps its value.
- R10: Timing and acceptance:
  - An unmapped or illegal request gives `rsp_valid` exactly one cycle after acceptance.
  - `req_ready` is low while a TLB request is pending.
  - `req_valid` is ignored while `req_ready` is low.
- R11: After reset:
  - `rsp_valid`, `tlb_req_valid`, `rsp_exc` and `badaddr` are 0.
  - `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Decoder can accept a request |
| req_vaddr | input | 64 | Virtual address |
| req_mode64 | input | 1 | 1 selects the 64-bit layout |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_probe | input | 1 | Lookup-only request, no exception side effects |
| tlb_req_valid | output | 1 | Lookup request to the TLB, held until acknowledged |
| tlb_req_vaddr | output | 64 | Address to translate |
| tlb_rsp_valid | input | 1 | TLB acknowledge |
| tlb_rsp_hit | input | 1 | TLB found a match |
| tlb_rsp_ppn | input | PA_W-PG_W | Physical page number from the TLB |
| tlb_rsp_cached | input | 1 | Cacheable attribute from the TLB |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_fail | output | 1 | Request failed |
| rsp_paddr | output | PA_W | Physical address |
| rsp_cached | output | 1 | Access is cacheable |
| rsp_exc | output | 3 | Exception code |
| badaddr | output | 64 | Last faulting virtual address |

## Verification
A wrong segment decision shows up on the first `rsp_valid` of that request. It appears either as a response that arrives in the wrong cycle, because a TLB round trip was started or skipped, or as a wrong address, cached flag or exception code. A stuck pending state keeps `req_ready` low and `tlb_req_valid` high, so the next request never completes. A stray write to the bad-address register is visible on `badaddr` in the cycle after the response. It is compared while the decoder is idle, so a corruption is caught within one cycle.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    SEG_MAPPED  = 2'd0,
    SEG_FIXED   = 2'd1,
    SEG_ILLEGAL = 2'd2
  } seg_kind_e;

  typedef enum logic [2:0] {
    EXC_NONE   = 3'd0,
    EXC_TLB_LD = 3'd1,
    EXC_TLB_ST = 3'd2,
    EXC_ADR_LD = 3'd3,
    EXC_ADR_ST = 3'd4
  } exc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_e;

  localparam int VA_W      = 64;
  localparam int FIX_OFF_W = 29;
endpackage

// File: rtl/vsd_seg32.sv
module vsd_seg32
  import vsd_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [31:0]     va,
  output seg_kind_e       kind,
  output logic            cached,
  output logic [PA_W-1:0] paddr
);
  logic [2:0] seg;

  always_comb begin
    seg    = va[31:29];
    kind   = SEG_MAPPED;
    cached = 1'b0;
    paddr  = {{(PA_W-FIX_OFF_W){1'b0}}, va[FIX_OFF_W-1:0]};
    unique case (seg)
      3'd4: begin
        kind   = SEG_FIXED;
        cached = 1'b1;
      end
      3'd5: begin
        kind   = SEG_FIXED;
        cached = 1'b0;
      end
      default: kind = SEG_MAPPED;
    endcase
  end
endmodule

// File: rtl/vsd_seg64.sv
module vsd_seg64
  import vsd_pkg::*;
#(
  parameter int         PA_W    = 36,
  parameter logic [2:0] UC_ATTR = 3'd2
) (
  input  logic [63:0]     va,
  output seg_kind_e       kind,
  output logic            cached,
  output logic [PA_W-1:0] paddr
);
  localparam int          N_WIN    = 8;
  localparam logic [23:0] WIN_BASE = 24'h800000;
  localparam logic [23:0] WIN_STEP = 24'h080000;

  logic [23:0]      region;
  logic [10:0]      sub;
  logic [2:0]       attr;
  logic [N_WIN-1:0] win_hit;
  logic             is_mapped_rgn;

  assign region = va[63:40];
  assign sub    = va[39:29];
  assign attr   = va[61:59];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    assign win_hit[g] = (region == (WIN_BASE + 24'(g) * WIN_STEP));
  end

  assign is_mapped_rgn = (region == 24'h000000) || (region == 24'h400000) ||
                         (region == 24'hC00000);

  always_comb begin
    kind   = SEG_ILLEGAL;
    cached = 1'b0;
    paddr  = {{(PA_W-FIX_OFF_W){1'b0}}, va[FIX_OFF_W-1:0]};
    if (is_mapped_rgn) begin
      kind = SEG_MAPPED;
    end else if (region == 24'hFFFFFF) begin
      unique case (sub)
        11'h7FC: begin
          kind   = SEG_FIXED;
          cached = 1'b1;
        end
        11'h7FD: begin
          kind   = SEG_FIXED;
          cached = 1'b0;
        end
        11'h7FE, 11'h7FF: kind = SEG_MAPPED;
        default:          kind = SEG_ILLEGAL;
      endcase
    end else if (|win_hit) begin
      kind   = SEG_FIXED;
      cached = (attr != UC_ATTR);
      paddr  = va[PA_W-1:0];
    end
  end

  always_comb begin
    assert ($onehot0(win_hit)) else $error("AST_WIN_ONEHOT");  // R5
  end
endmodule

// File: rtl/vsd_fault.sv
module vsd_fault
  import vsd_pkg::*;
(
  input  logic addr_err,
  input  logic tlb_miss,
  input  logic is_store,
  input  logic probe,
  output exc_e exc,
  output logic fail
);
  always_comb begin
    fail = addr_err | tlb_miss;
    exc  = EXC_NONE;
    if (!probe) begin
      if (addr_err)      exc = is_store ? EXC_ADR_ST : EXC_ADR_LD;
      else if (tlb_miss) exc = is_store ? EXC_TLB_ST : EXC_TLB_LD;
    end
  end
endmodule

// File: rtl/vsd_top.sv
module vsd_top
  import vsd_pkg::*;
#(
  parameter int         PA_W    = 36,
  parameter int         PG_W    = 12,
  parameter logic [2:0] UC_ATTR = 3'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [63:0]          req_vaddr,
  input  logic                 req_mode64,
  input  logic                 req_store,
  input  logic                 req_probe,
  output logic                 tlb_req_valid,
  output logic [63:0]          tlb_req_vaddr,
  input  logic                 tlb_rsp_valid,
  input  logic                 tlb_rsp_hit,
  input  logic [PA_W-PG_W-1:0] tlb_rsp_ppn,
  input  logic                 tlb_rsp_cached,
  output logic                 rsp_valid,
  output logic                 rsp_fail,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_cached,
  output logic [2:0]           rsp_exc,
  output logic [63:0]          badaddr
);
  localparam int PPN_W = PA_W - PG_W;

  walk_st_e          st_q, st_d;
  logic [VA_W-1:0]   pend_va_q;
  logic              pend_store_q, pend_probe_q;

  seg_kind_e         k32, k64, kind;
  logic              c32, c64, dec_cached;
  logic [PA_W-1:0]   p32, p64, dec_paddr;
  logic [VA_W-1:0]   va_eff;

  logic              accept, go_tlb, fix_done, tlb_done;
  logic              f_addr_err, f_miss, f_store, f_probe;
  exc_e              f_exc;
  logic              f_fail;

  logic              rsp_valid_d, rsp_fail_d, rsp_cached_d, bad_en;
  logic [PA_W-1:0]   rsp_paddr_d;
  logic [VA_W-1:0]   bad_d;

  vsd_seg32 #(.PA_W(PA_W)) u_seg32 (
    .va     (req_vaddr[31:0]),
    .kind   (k32),
    .cached (c32),
    .paddr  (p32)
  );

  vsd_seg64 #(.PA_W(PA_W), .UC_ATTR(UC_ATTR)) u_seg64 (
    .va     (req_vaddr),
    .kind   (k64),
    .cached (c64),
    .paddr  (p64)
  );

  vsd_fault u_fault (
    .addr_err (f_addr_err),
    .tlb_miss (f_miss),
    .is_store (f_store),
    .probe    (f_probe),
    .exc      (f_exc),
    .fail     (f_fail)
  );

  assign req_ready     = (st_q == ST_IDLE);
  assign tlb_req_valid = (st_q == ST_WAIT);
  assign tlb_req_vaddr = pend_va_q;

  // Decode selection by addressing mode
  always_comb begin
    if (req_mode64) begin
      va_eff     = req_vaddr;
      kind       = k64;
      dec_cached = c64;
      dec_paddr  = p64;
    end else begin
      va_eff     = {{32{req_vaddr[31]}}, req_vaddr[31:0]};
      kind       = k32;
      dec_cached = c32;
      dec_paddr  = p32;
    end
  end

  assign accept   = req_valid && req_ready;
  assign go_tlb   = accept && (kind == SEG_MAPPED);
  assign fix_done = accept && (kind != SEG_MAPPED);
  assign tlb_done = (st_q == ST_WAIT) && tlb_rsp_valid;

  // Fault source selection
  always_comb begin
    f_addr_err = 1'b0;
    f_miss     = 1'b0;
    f_store    = req_store;
    f_probe    = req_probe;
    if (tlb_done) begin
      f_miss  = !tlb_rsp_hit;
      f_store = pend_store_q;
      f_probe = pend_probe_q;
    end else begin
      f_addr_err = (kind == SEG_ILLEGAL);
    end
  end

  // Next state and response
  always_comb begin
    st_d = st_q;
    if (go_tlb)        st_d = ST_WAIT;
    else if (tlb_done) st_d = ST_IDLE;

    rsp_valid_d = fix_done || tlb_done;
    rsp_fail_d  = f_fail;
    if (tlb_done) begin
      rsp_paddr_d  = tlb_rsp_hit ? {tlb_rsp_ppn[PPN_W-1:0], pend_va_q[PG_W-1:0]} : '0;
      rsp_cached_d = tlb_rsp_hit && tlb_rsp_cached;
      bad_d        = pend_va_q;
    end else begin
      rsp_paddr_d  = (kind == SEG_FIXED) ? dec_paddr : '0;
      rsp_cached_d = (kind == SEG_FIXED) && dec_cached;
      bad_d        = va_eff;
    end
    bad_en = rsp_valid_d && (f_exc != EXC_NONE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      pend_va_q    <= '0;
      pend_store_q <= 1'b0;
      pend_probe_q <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_fail     <= 1'b0;
      rsp_paddr    <= '0;
      rsp_cached   <= 1'b0;
      rsp_exc      <= 3'd0;
      badaddr      <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= rsp_valid_d;
      if (go_tlb) begin
        pend_va_q    <= va_eff;
        pend_store_q <= req_store;
        pend_probe_q <= req_probe;
      end
      if (rsp_valid_d) begin
        rsp_fail   <= rsp_fail_d;
        rsp_paddr  <= rsp_paddr_d;
        rsp_cached <= rsp_cached_d;
        rsp_exc    <= f_exc;
      end
      if (bad_en) begin
        badaddr <= bad_d;
      end
    end
  end

  // Assertions
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && kind != SEG_MAPPED) |=> rsp_valid) else $error("AST_FIXED_LATENCY");  // R10
  AST_TLB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && !tlb_rsp_valid) |=> (tlb_req_valid && $stable(tlb_req_vaddr))) else $error("AST_TLB_HOLD");  // R7
  AST_TLB_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && tlb_rsp_valid) |=> (rsp_valid && !tlb_req_valid)) else $error("AST_TLB_DONE");  // R7
  AST_BAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_exc == 3'd0 || !rsp_valid) |-> (!rsp_valid || $stable(badaddr))) else $error("AST_BAD_STABLE");  // R9
  AST_EXC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc != 3'd0) |-> rsp_fail) else $error("AST_EXC_FAILS");  // R8
  AST_NO_RSP_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req_valid && $past(tlb_req_valid)) |-> !rsp_valid) else $error("AST_NO_RSP_WHILE_WAIT");  // R10
endmodule

// File: tb/tb_vsd_top.sv
module tb_vsd_top;
  localparam int PA_W  = 36;
  localparam int PG_W  = 12;
  localparam int PPN_W = PA_W - PG_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_mode64, req_store, req_probe;
  logic [63:0]       req_vaddr;
  logic              tlb_req_valid;
  logic [63:0]       tlb_req_vaddr;
  logic              tlb_rsp_valid, tlb_rsp_hit, tlb_rsp_cached;
  logic [PPN_W-1:0]  tlb_rsp_ppn;
  logic              rsp_valid, rsp_fail, rsp_cached;
  logic [PA_W-1:0]   rsp_paddr;
  logic [2:0]        rsp_exc;
  logic [63:0]       badaddr;

  int          n_checks = 0;
  int          n_fail   = 0;
  int          tlb_delay = 0;
  int          tlb_cnt   = 0;
  logic        busy = 1'b0;
  logic        done = 1'b0;
  logic [63:0] model_bad = '0;

  logic [51:0]      t_vpn [4];
  logic [PPN_W-1:0] t_ppn [4];
  logic             t_c   [4];

  always #4 clk = ~clk;

  vsd_top dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_mode64(req_mode64), .req_store(req_store), .req_probe(req_probe),
    .tlb_req_valid(tlb_req_valid), .tlb_req_vaddr(tlb_req_vaddr),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_hit(tlb_rsp_hit),
    .tlb_rsp_ppn(tlb_rsp_ppn), .tlb_rsp_cached(tlb_rsp_cached),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_paddr(rsp_paddr),
    .rsp_cached(rsp_cached), .rsp_exc(rsp_exc), .badaddr(badaddr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // Stub TLB: answers after tlb_delay waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      tlb_rsp_valid  = 1'b0;
      tlb_rsp_hit    = 1'b0;
      tlb_rsp_ppn    = '0;
      tlb_rsp_cached = 1'b0;
      tlb_cnt        = 0;
    end else if (tlb_rsp_valid) begin
      tlb_rsp_valid = 1'b0;
      tlb_cnt       = 0;
    end else if (tlb_req_valid) begin
      if (tlb_cnt >= tlb_delay) begin
        tlb_rsp_hit    = 1'b0;
        tlb_rsp_ppn    = '0;
        tlb_rsp_cached = 1'b0;
        for (int i = 0; i < 4; i++) begin
          if (t_vpn[i] == tlb_req_vaddr[63:12]) begin
            tlb_rsp_hit    = 1'b1;
            tlb_rsp_ppn    = t_ppn[i];
            tlb_rsp_cached = t_c[i];
          end
        end
        tlb_rsp_valid = 1'b1;
      end else begin
        tlb_cnt++;
      end
    end
  end

  // Idle monitor, every clock
  always @(negedge clk) begin
    if (rst_n && !busy && !done) begin
      chk("R10 no response while idle", {63'd0, rsp_valid}, 64'd0);
      chk("R9 badaddr idle compare", badaddr, model_bad);
    end
  end

  // Behavioural reference model
  task automatic model(input logic [63:0] va_in, input logic m64, input logic st, input logic pr,
                       output int kind, output logic [63:0] va, output logic [35:0] pa,
                       output logic c, output logic [2:0] exc, output logic fail);
    logic [23:0] rg;
    logic [10:0] sb;
    logic        hit;
    va = m64 ? va_in : {{32{va_in[31]}}, va_in[31:0]};
    pa = '0; c = 1'b0; kind = 2;
    if (!m64) begin
      if (va[31:29] == 3'd4)      begin kind = 1; c = 1'b1; pa = 36'(va & 64'h1FFF_FFFF); end
      else if (va[31:29] == 3'd5) begin kind = 1; c = 1'b0; pa = 36'(va & 64'h1FFF_FFFF); end
      else kind = 0;
    end else begin
      rg = va[63:40];
      sb = va[39:29];
      if (rg == 24'h0 || rg == 24'h400000 || rg == 24'hC00000) kind = 0;
      else if (rg == 24'hFFFFFF) begin
        if (sb == 11'h7FC)      begin kind = 1; c = 1'b1; pa = 36'(va & 64'h1FFF_FFFF); end
        else if (sb == 11'h7FD) begin kind = 1; c = 1'b0; pa = 36'(va & 64'h1FFF_FFFF); end
        else if (sb >= 11'h7FE) kind = 0;
        else kind = 2;
      end else if (rg >= 24'h800000 && rg <= 24'hB80000 && (rg % 24'h080000) == 0) begin
        kind = 1;
        pa   = va[35:0];
        c    = (((va >> 59) & 64'h7) != 64'd2);
      end else kind = 2;
    end
    exc = 3'd0; fail = 1'b0;
    if (kind == 0) begin
      hit = 1'b0;
      for (int i = 0; i < 4; i++) begin
        if (t_vpn[i] == va[63:12]) begin
          hit = 1'b1;
          pa  = {t_ppn[i], va[11:0]};
          c   = t_c[i];
        end
      end
      if (!hit) begin fail = 1'b1; exc = st ? 3'd2 : 3'd1; end
    end else if (kind == 2) begin
      fail = 1'b1; exc = st ? 3'd4 : 3'd3;
    end
    if (fail) begin pa = '0; c = 1'b0; end
    if (pr) exc = 3'd0;
  endtask

  task automatic run(input string tag, input logic [63:0] va_in, input logic m64,
                     input logic st, input logic pr, input logic inject);
    int          kind;
    int          lat;
    int          exp_lat;
    logic [63:0] va;
    logic [35:0] pa;
    logic        c, fail;
    logic [2:0]  exc;
    model(va_in, m64, st, pr, kind, va, pa, c, exc, fail);
    exp_lat = (kind == 0) ? 2 + tlb_delay : 1;
    @(negedge clk);
    busy       = 1'b1;
    req_vaddr  = va_in;
    req_mode64 = m64;
    req_store  = st;
    req_probe  = pr;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (kind == 0) begin
      chk({tag, " R10 ready low while TLB pending"}, {63'd0, req_ready}, 64'd0);
      chk({tag, " R7 TLB request raised"}, {63'd0, tlb_req_valid}, 64'd1);
      chk({tag, " R7 TLB request address"}, tlb_req_vaddr, va);
      if (inject) begin
        req_vaddr  = 64'h1234_0000_0000_0000;
        req_mode64 = 1'b1;
        req_store  = 1'b1;
        req_probe  = 1'b0;
        req_valid  = 1'b1;
      end
    end
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (!rsp_valid && kind == 0 && tlb_req_valid)
        chk({tag, " R7 TLB address held"}, tlb_req_vaddr, va);
    end
    chk({tag, " R10/R7 latency"}, 64'(lat), 64'(exp_lat));
    chk({tag, " R8 fail"},    {63'd0, rsp_fail}, {63'd0, fail});
    chk({tag, " R2/R5 paddr"}, 64'(rsp_paddr), 64'(pa));
    chk({tag, " R5 cached"},  {63'd0, rsp_cached}, {63'd0, c});
    chk({tag, " R8/R9 exc"},  64'(rsp_exc), 64'(exc));
    if (exc != 3'd0) model_bad = va;
    chk({tag, " R8/R9 badaddr"}, badaddr, model_bad);
    @(negedge clk);
    chk({tag, " R10 single pulse"}, {63'd0, rsp_valid}, 64'd0);
    busy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    finish_up();
  end

  initial begin
    t_vpn[0] = 52'h0000_0000_0040_1; t_ppn[0] = 24'h00ABC; t_c[0] = 1'b1;
    t_vpn[1] = 52'hFFFF_FFFF_C000_5; t_ppn[1] = 24'h12345; t_c[1] = 1'b0;
    t_vpn[2] = 52'h0000_0012_3456_7; t_ppn[2] = 24'hFEDCB; t_c[2] = 1'b1;
    t_vpn[3] = 52'hFFFF_FFFF_E001_0; t_ppn[3] = 24'h00001; t_c[3] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    req_mode64 = 1'b0; req_store = 1'b0; req_probe = 1'b0;
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid reset",     {63'd0, rsp_valid}, 64'd0);
    chk("R11 tlb_req_valid reset", {63'd0, tlb_req_valid}, 64'd0);
    chk("R11 req_ready reset",     {63'd0, req_ready}, 64'd1);
    chk("R11 rsp_exc reset",       64'(rsp_exc), 64'd0);
    chk("R11 badaddr reset",       badaddr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    busy = 1'b0;

    // 32-bit layout
    run("R2 seg4 junk upper",  64'hDEAD_BEEF_8001_2345, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R2 seg5",             64'h0000_0000_BFC0_0ABC, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R1 user hit junk",    64'hDEAD_BEEF_0040_1234, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R1 user miss store",  64'h1234_5678_7FFF_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R1 seg6 hit",         64'h0000_0000_C000_5678, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R1 seg6 miss load",   64'h0000_0000_C0F0_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R9 seg7 probe miss",  64'h0000_0000_E777_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    run("R1 seg7 probe hit",   64'h0000_0000_E001_0ABC, 1'b0, 1'b0, 1'b1, 1'b0);

    // 64-bit layout
    tlb_delay = 2;
    run("R3 xuser hit",        64'h0000_0012_3456_7FFF, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R3 xsuper miss st",   64'h4000_0000_0000_1000, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R9 xkern probe miss", 64'hC000_0000_0000_2000, 1'b1, 1'b0, 1'b1, 1'b0);
    run("R3 sub 7FF hit",      64'hFFFF_FFFF_E001_0ABC, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R3 sub 7FE miss",     64'hFFFF_FFFF_C000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R4 sub 7FC",          64'hFFFF_FFFF_8000_1234, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R4 sub 7FD",          64'hFFFF_FFFF_A123_4567, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R4 sub 000 load",     64'hFFFF_FF00_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R9 sub 7FB probe",    64'hFFFF_FFFF_7000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
    run("R5 window attr2",     64'h9000_0001_2345_6789, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R5 window attr3",     64'h9800_000F_FFFF_F000, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R5 window attr0",     64'h8000_0000_0000_0FFF, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R5 window top",       64'hB800_00AB_CDEF_0123, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R6 region 880001 st", 64'h8800_0100_0000_0000, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R6 region 100000 ld", 64'h1000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R6 region C00001",    64'hC000_0100_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0);

    // Request while busy must be ignored
    tlb_delay = 3;
    run("R10 ignore when busy", 64'h0000_0012_3456_7000, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    tlb_delay = 0;
    run("R7 back to back",     64'h0000_0000_0040_1FFC, 1'b1, 1'b1, 1'b0, 1'b0);
    run("R8 after TLB",        64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule